// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Data Cache

This block sits between a processor load/store port and a slower word-wide memory. It keeps 8 KB of data. The storage is two ways of 512 sets, and each entry holds one 8-byte line made of two 32-bit words. On every request, both ways are looked up with the same set index. The valid flag and stored tag of each way are compared with the request. A read that hits returns the selected word in the same cycle, with no stall. A read that misses holds the processor in stall and sends one line request to memory. It then accepts two returning words, lower word first, and writes them into a victim way. After that the original access is repeated as an ordinary hit.

Every write is passed on to memory in the cycle it is presented, and the processor is not stalled. On a hit, the cached word is updated at the same clock edge. On a miss, the cache arrays stay unchanged, because lines are not allocated on writes. The processor must keep its request and address steady for as long as stall is high.

A state machine runs the block:
- `S_INIT` clears the valid flags, one set per cycle, then moves to `S_IDLE`.
- `S_IDLE` serves hits and writes. A read miss moves it to `S_FETCH_REQ`.
- `S_FETCH_REQ` sends the line address for one cycle, then moves to `S_FETCH_LO`.
- `S_FETCH_LO` waits for the first data beat, then moves to `S_FETCH_HI`.
- `S_FETCH_HI` waits for the second beat, fills the victim way, and returns to `S_IDLE`.

Top module: `cache_2way_wt`

## Requirements
- R1: An address splits into tag = bits [31:12], set index = bits [11:3], and word select = bit 2, where 1 selects the upper word of the line. Bits [1:0] have no effect on reads.
- R2: After reset is released, stall stays high for exactly 512 cycles while the valid flags are cleared. After that, no stale data can hit: the first read of any line misses.
- R3: A read that hits keeps stall low in that same cycle and returns the stored word chosen by bit 2.
- R4: A lookup never hits in both ways at once. Two different lines of one set can be resident together, and each returns its own data.
- R5: A read miss raises stall in the cycle it is presented. In the following cycle, a memory read request (mem_req high, mem_we low) is issued for exactly one cycle, with a line-aligned address (bits [2:0] zero).
- R6: The refill takes the first data beat as the lower word (address bit 2 = 0) and the second beat as the upper word. It then repeats the access as a hit. When memory returns the beats 4 and 5 cycles after the request cycle, stall is high for 7 cycles.
- R7: The victim is an invalid way if one exists, preferring way 0. When both ways are valid, it is chosen by bit 0 of an 8-bit LFSR with a fixed reset seed. A third line in a full set evicts exactly one of the two resident lines.
- R8: A write is forwarded in the cycle it is presented: mem_req and mem_we high, mem_addr equal to the request address with bits [1:0] cleared, mem_wdata equal to the write data. Stall stays low.
- R9: A write miss changes no cache entry. A later read of that address misses and returns the value now held in memory.
- R10: A write hit replaces only the selected word of the line. The other word of the line keeps its value, and both words remain hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write data word |
| cpu_rdata | output | 32 | Read data word, valid when stall is low |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1 = word write, 0 = line read |
| mem_addr | output | 32 | Memory address (line-aligned for reads) |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |

## Verification
Hits and writes give their result combinationally, in the cycle the request is driven. So the bench samples stall, the read data and the memory-side write fields one time unit after driving the inputs, before the next rising edge. For a read miss, the bench samples once per cycle and counts stall-high cycles until the stall drops. It records in which of those cycles the line request appears; the request is expected in cycle 1, and the stall is expected to last 7 cycles for a memory model that answers 4 and 5 cycles after the request. The reset sweep is measured the same way, and 512 stall-high samples are expected from the release of reset.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int WAYS   = 2;

    typedef enum logic [2:0] {
        S_INIT,
        S_IDLE,
        S_FETCH_REQ,
        S_FETCH_LO,
        S_FETCH_HI
    } cstate_t;
endpackage

// File: rtl/victim_lfsr.sv
module victim_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'hA1
) (
    input  logic clk,
    input  logic rst,
    output logic pick
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= SEED;
        end else if (q[0]) begin
            q <= (q >> 1) ^ TAPS;
        end else begin
            q <= q >> 1;
        end
    end

    assign pick = q[0];

    // R7: the pseudo-random source must never lock up in the all-zero state
    a_r7_lfsr_live: assert property (@(posedge clk) disable iff (rst) q != '0);
endmodule

// File: rtl/way_bank.sv
module way_bank #(
    parameter int SETS   = 512,
    parameter int TAG_W  = 20,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  look_idx,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic              look_valid,
    output logic [WORD_W-1:0] rd_lo,
    output logic [WORD_W-1:0] rd_hi,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [WORD_W-1:0] fill_lo,
    input  logic [WORD_W-1:0] fill_hi,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wr_data
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [WORD_W-1:0] lo_q   [SETS];
    logic [WORD_W-1:0] hi_q   [SETS];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            valid_q[clr_idx] <= 1'b0;
        end else if (fill_en) begin
            valid_q[look_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[look_idx] <= fill_tag;
            lo_q[look_idx]  <= fill_lo;
            hi_q[look_idx]  <= fill_hi;
        end else if (wr_en) begin
            if (wr_hi) begin
                hi_q[look_idx] <= wr_data;
            end else begin
                lo_q[look_idx] <= wr_data;
            end
        end
    end

    assign look_valid = valid_q[look_idx];
    assign hit        = look_valid && (tag_q[look_idx] == look_tag);
    assign rd_lo      = lo_q[look_idx];
    assign rd_hi      = hi_q[look_idx];
endmodule

// File: rtl/cache_2way_wt.sv
module cache_2way_wt
    import cache_pkg::*;
#(
    parameter int SETS      = 512,
    parameter int LINE_B    = 8,
    parameter logic [7:0] LFSR_SEED = 8'hA1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int OFF_W  = $clog2(LINE_B);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int SEL_B  = OFF_W - 1;

    cstate_t state, nxt;
    logic [IDX_W-1:0]  init_cnt;
    logic [WORD_W-1:0] lo_buf;

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic             req_hi;

    assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx = cpu_addr[OFF_W +: IDX_W];
    assign req_hi  = cpu_addr[SEL_B];

    logic [WAYS-1:0]   hit, vld, fill_way;
    logic [WORD_W-1:0] way_lo [WAYS];
    logic [WORD_W-1:0] way_hi [WAYS];
    logic              clr_en, fill_en, wr_en, hit_any, lfsr_pick, victim;

    victim_lfsr #(.W(8), .TAPS(8'hB8), .SEED(LFSR_SEED)) u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .pick (lfsr_pick)
    );

    always_comb begin
        if (!vld[0]) begin
            victim = 1'b0;
        end else if (!vld[1]) begin
            victim = 1'b1;
        end else begin
            victim = lfsr_pick;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign fill_way[w] = fill_en && (victim == w[0]);
        way_bank #(.SETS(SETS), .TAG_W(TAG_W), .WORD_W(WORD_W)) u_bank (
            .clk        (clk),
            .look_idx   (req_idx),
            .look_tag   (req_tag),
            .hit        (hit[w]),
            .look_valid (vld[w]),
            .rd_lo      (way_lo[w]),
            .rd_hi      (way_hi[w]),
            .clr_en     (clr_en),
            .clr_idx    (init_cnt),
            .fill_en    (fill_way[w]),
            .fill_tag   (req_tag),
            .fill_lo    (lo_buf),
            .fill_hi    (mem_rdata),
            .wr_en      (wr_en && hit[w]),
            .wr_hi      (req_hi),
            .wr_data    (cpu_wdata)
        );
    end

    assign hit_any   = |hit;
    assign cpu_rdata = hit[1] ? (req_hi ? way_hi[1] : way_lo[1])
                              : (req_hi ? way_hi[0] : way_lo[0]);

    // state register, sweep counter and low-word holding register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_INIT;
            init_cnt <= '0;
            lo_buf   <= '0;
        end else begin
            state <= nxt;
            if (state == S_INIT) begin
                init_cnt <= init_cnt + 1'b1;
            end
            if (state == S_FETCH_LO && mem_rvalid) begin
                lo_buf <= mem_rdata;
            end
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_INIT:      if (init_cnt == IDX_W'(SETS - 1)) nxt = S_IDLE;
            S_IDLE:      if (cpu_req && !cpu_we && !hit_any) nxt = S_FETCH_REQ;
            S_FETCH_REQ: nxt = S_FETCH_LO;
            S_FETCH_LO:  if (mem_rvalid) nxt = S_FETCH_HI;
            S_FETCH_HI:  if (mem_rvalid) nxt = S_IDLE;
            default:     nxt = S_INIT;
        endcase
    end

    // outputs
    always_comb begin
        cpu_stall = 1'b1;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        mem_wdata = cpu_wdata;
        clr_en    = 1'b0;
        fill_en   = 1'b0;
        wr_en     = 1'b0;
        unique case (state)
            S_INIT: begin
                clr_en = 1'b1;
            end
            S_IDLE: begin
                cpu_stall = cpu_req && !cpu_we && !hit_any;
                if (cpu_req && cpu_we) begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                    wr_en   = 1'b1;
                end
            end
            S_FETCH_REQ: begin
                mem_req  = 1'b1;
                mem_addr = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            end
            S_FETCH_LO: begin
            end
            S_FETCH_HI: begin
                fill_en = mem_rvalid;
            end
            default: begin
            end
        endcase
    end

    // R4: the refill policy keeps a line in at most one way
    a_r4_single_way: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> $onehot0(hit));

    // R5: a line read request lasts exactly one cycle
    a_r5_one_line_req: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !(mem_req && !mem_we));

    // R6: after the second beat the held request replays as a hit
    a_r6_replay_hits: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH_HI && mem_rvalid && cpu_req) |=> hit_any);

    // R2: no memory traffic while the valid flags are being swept
    a_r2_quiet_init: assert property (@(posedge clk) disable iff (rst)
        (state == S_INIT) |-> !mem_req);
endmodule

// File: tb/sim_cache_2way_wt.sv
`timescale 1ns/100ps
module sim_cache_2way_wt;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_stall, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata  = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cache_2way_wt u0 (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // memory model: writes stored sparsely; line reads answer 4 and 5 cycles after the request
    logic [31:0] wmem [logic [31:0]];
    logic [31:0] line_addr = '0;
    int          cnt = 0;

    function automatic logic [31:0] mexp(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        if (wmem.exists(w)) return wmem[w];
        return w ^ 32'h5A5A_A5A5;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && mem_we) begin
            wmem[mem_addr] = mem_wdata;
        end
        if (mem_req && !mem_we) begin
            line_addr = mem_addr;
            cnt <= 1;
        end else if (cnt != 0) begin
            cnt <= cnt + 1;
            if (cnt == 3) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mexp(line_addr);
            end
            if (cnt == 4) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mexp(line_addr | 32'h4);
                cnt <= 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // read; exp_n < 0 means the stall length is only reported
    task automatic cpu_read(input logic [31:0] a, input int exp_n, input string req, output int n);
        int nreq, reqcyc;
        logic [31:0] reqaddr;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1;
        n = 0; nreq = 0; reqcyc = -1; reqaddr = '0;
        while (cpu_stall && n < 50) begin
            if (mem_req && !mem_we) begin
                nreq++;
                if (reqcyc < 0) reqcyc = n;
                reqaddr = mem_addr;
            end
            @(negedge clk); #1;
            n++;
        end
        if (exp_n >= 0) check(n == exp_n, req, "stall cycles", n, exp_n);
        check(cpu_rdata == mexp(a), req, "read data", cpu_rdata, mexp(a));
        if (exp_n > 0) begin
            check(nreq == 1 && reqcyc == 1, "R5", "line request count/cycle", nreq, reqcyc);
            check(reqaddr == {a[31:3], 3'b000}, "R5", "line address", reqaddr, {a[31:3], 3'b000});
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        #1;
        check(!cpu_stall, req, "write stall", cpu_stall, 0);
        check(mem_req && mem_we, "R8", "write forward strobes", {mem_req, mem_we}, 2'b11);
        check(mem_addr == {a[31:2], 2'b00}, "R8", "write address", mem_addr, {a[31:2], 2'b00});
        check(mem_wdata == d, "R8", "write data", mem_wdata, d);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic t_reset;
        int n;
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        #1;
        check(cpu_stall && !mem_req, "R2", "reset state stall/req", {cpu_stall, mem_req}, 2'b10);
        @(negedge clk);
        rst = 1'b0;
        #1;
        n = 0;
        while (cpu_stall && n < 1000) begin
            @(negedge clk); #1;
            n++;
        end
        check(n == 512, "R2", "init sweep length", n, 512);
    endtask

    localparam logic [31:0] A = 32'h0001_2344;  // set 0x068, tag 0x12, upper word
    localparam logic [31:0] B = 32'h0001_3344;  // same set, tag 0x13
    localparam logic [31:0] C = 32'h0004_0010;  // another set, never loaded before its write
    localparam logic [31:0] D = 32'h0001_4340;  // same set as A, tag 0x14, lower word

    task automatic t_miss_then_hit;
        int n;
        cpu_read(A, 7, "R6", n);                // first access after the sweep misses (R2)
        cpu_read(A, 0, "R3", n);
        cpu_read(A ^ 32'h4, 0, "R6", n);        // lower word came from the first beat
        cpu_read(A | 32'h3, 0, "R1", n);        // bits [1:0] ignored
        cpu_read(A + 32'h8, 7, "R1", n);        // next index misses
    endtask

    task automatic t_two_lines_one_set;
        int n;
        cpu_read(B, 7, "R7", n);
        cpu_read(A, 0, "R4", n);
        cpu_read(B, 0, "R4", n);
    endtask

    task automatic t_write_hit;
        int n;
        cpu_write(A, 32'hDEAD_0001, "R8");
        cpu_read(A, 0, "R10", n);
        cpu_read(A ^ 32'h4, 0, "R10", n);
    endtask

    task automatic t_write_miss;
        int n;
        cpu_write(C, 32'hBEEF_0002, "R9");
        cpu_read(C, 7, "R9", n);
    endtask

    task automatic t_eviction;
        int na, nb;
        cpu_read(D, 7, "R7", na);
        cpu_read(D, 0, "R7", na);
        cpu_read(A, -1, "R7", na);
        check(na == 0 || na == 7, "R7", "A stall after eviction", na, 0);
        if (na == 0) begin
            cpu_read(B, 7, "R7", nb);           // A stayed, so B was the victim
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_miss_then_hit();
        t_two_lines_one_set();
        t_write_hit();
        t_write_miss();
        t_eviction();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule